// File: doc/BRIEF.md
# Bidirectional Cascadable LCD Segment Driver

This block is the digital core of an 80-channel dot-matrix LCD segment driver. Pixel data arrives serially and is clocked into two independent 40-cell shift halves on the falling edge of a slow shift clock. A level-sensitive strobe copies the combined 80-bit pattern into a display latch. Each channel then reports one of four panel drive levels as a 2-bit code. The level depends on the channel's latched dot and on the frame-alternation input.

Each half has its own direction input. The direction decides which of the half's two serial pins is the input and which is the output. Each pin is modelled as a separate input, output and output-enable, so the surrounding pad logic can build the tristate. When the low-end data pin of the second half is tied to the high-end pin of the first half, and both halves shift upward, the two halves form one 80-bit chain. The last pin can feed a following driver in the same way.

The whole block runs on one fast system clock. The shift clock, the strobe and the four serial data inputs each pass through a synchronizer before use. Reset is synchronous and active high.

Top module: `lcd_seg_driver`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all 80 latched dots and all shift cells are zero. Every channel therefore shows the unselected code for the current alternation input (01 when it is 0, 10 when it is 1), and every serial output reads 0.
- R2: Channel k (k = 1..80) reports its level on `seg_lvl[2k-1:2k-2]`. The level depends on the latched dot and the alternation input `frame_alt`: dot 1 with alt 1 gives 11, dot 1 with alt 0 gives 00, dot 0 with alt 1 gives 10, and dot 0 with alt 0 gives 01. A change of `frame_alt` reaches the outputs without any re-latching.
- R3: When `dir_a` is 0, each shift moves half A from channel 1 toward channel 40. The bit on `a_lo_i` enters channel 1, and `a_hi_o` shows the bit held at channel 40.
- R4: When `dir_a` is 1, each shift moves half A from channel 40 toward channel 1. The bit on `a_hi_i` enters channel 40, and `a_lo_o` shows the bit held at channel 1.
- R5: When `dir_b` is 0, each shift moves half B from channel 41 toward 80. The bit on `b_lo_i` enters channel 41, and `b_hi_o` shows channel 80.
- R6: When `dir_b` is 1, each shift moves half B from channel 80 toward 41. The bit on `b_hi_i` enters channel 80, and `b_lo_o` shows channel 41.
- R7: The shift cells move one place only on a high-to-low transition of `shift_clk`. A rising edge, or a steady level, leaves them unchanged.
- R8: While `latch_strb` is high, the latch follows the shift cells. While it is low, the latch and the channel levels hold, even if more data is shifted in.
- R9: In each half, only the pin that currently acts as the serial output has its enable set (`*_hi_oe` when the direction is 0, `*_lo_oe` when it is 1). The serial output on the non-enabled pin reads 0.
- R10: With `b_lo_i` wired to `a_hi_o` and both directions at 0, 80 shifts place the first bit shifted into `a_lo_i` at channel 80 and the last bit at channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Serial shift clock, acts on its falling edge |
| latch_strb | input | 1 | Level-sensitive latch strobe |
| frame_alt | input | 1 | Frame alternation signal |
| dir_a | input | 1 | Direction of half A (channels 1..40), 1 = toward channel 1 |
| dir_b | input | 1 | Direction of half B (channels 41..80), 1 = toward channel 41 |
| a_lo_i | input | 1 | Half A low-end pin, input side |
| a_lo_o | output | 1 | Half A low-end pin, output side |
| a_lo_oe | output | 1 | Half A low-end pin, output enable |
| a_hi_i | input | 1 | Half A high-end pin, input side |
| a_hi_o | output | 1 | Half A high-end pin, output side |
| a_hi_oe | output | 1 | Half A high-end pin, output enable |
| b_lo_i | input | 1 | Half B low-end pin, input side |
| b_lo_o | output | 1 | Half B low-end pin, output side |
| b_lo_oe | output | 1 | Half B low-end pin, output enable |
| b_hi_i | input | 1 | Half B high-end pin, input side |
| b_hi_o | output | 1 | Half B high-end pin, output side |
| b_hi_oe | output | 1 | Half B high-end pin, output enable |
| seg_lvl | output | 160 | Two-bit drive level code per channel, channel 1 in bits 1:0 |

## Verification
The bench uses the default parameters: 40 cells per half and two synchronizer stages. With these values a full load of each half takes 40 shifts, so all four direction combinations can be filled completely. The 80-bit cascade can be checked from end to end, with the first bit arriving at the far channel. The two-stage synchronizer sets the fixed latency that the bench allows for between a shift-clock edge and the resulting update of the cells and outputs.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

  typedef enum logic [1:0] {
    LVL_VDD = 2'b00,
    LVL_V2  = 2'b01,
    LVL_V3  = 2'b10,
    LVL_VEE = 2'b11
  } drive_lvl_e;

  // Level chosen from a channel's latched dot and the alternation phase.
  function automatic drive_lvl_e pick_level(input logic dot, input logic alt);
    drive_lvl_e lvl;
    case ({dot, alt})
      2'b11:   lvl = LVL_VEE;
      2'b10:   lvl = LVL_VDD;
      2'b01:   lvl = LVL_V3;
      default: lvl = LVL_V2;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/lcdseg_sync.sv
module lcdseg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/lcdseg_half.sv
module lcdseg_half #(
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_evt,
  input  logic             toward_lo,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  output logic             ser_lo_out,
  output logic             ser_lo_oe,
  output logic             ser_hi_out,
  output logic             ser_hi_oe,
  output logic [WIDTH-1:0] cells
);

  // cells[0] is the half's low-end channel, cells[WIDTH-1] the high end.
  always_ff @(posedge clk) begin
    if (rst) begin
      cells <= '0;
    end else if (shift_evt) begin
      if (toward_lo) cells <= {ser_hi_in, cells[WIDTH-1:1]};
      else           cells <= {cells[WIDTH-2:0], ser_lo_in};
    end
  end

  assign ser_lo_oe  = toward_lo;
  assign ser_hi_oe  = ~toward_lo;
  assign ser_lo_out = toward_lo ? cells[0] : 1'b0;
  assign ser_hi_out = toward_lo ? 1'b0 : cells[WIDTH-1];

  AST_HALF_STILL: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(cells)); // R7
  AST_ENTRY_LO: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !toward_lo) |=> cells[0] == $past(ser_lo_in)); // R3
  AST_ENTRY_HI: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && toward_lo) |=> cells[WIDTH-1] == $past(ser_hi_in)); // R4
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $countones({ser_lo_oe, ser_hi_oe}) == 1); // R9

endmodule

// File: rtl/lcdseg_level.sv
module lcdseg_level
  import lcdseg_pkg::*;
#(
  parameter int CHANNELS = 80
) (
  input  logic [CHANNELS-1:0]   dots,
  input  logic                  alt,
  output logic [2*CHANNELS-1:0] lvl
);

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      assign lvl[2*c +: 2] = pick_level(dots[c], alt);
    end
  endgenerate

endmodule

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver
  import lcdseg_pkg::*;
#(
  parameter int HALF_W      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_clk,
  input  logic                    latch_strb,
  input  logic                    frame_alt,
  input  logic                    dir_a,
  input  logic                    dir_b,
  input  logic                    a_lo_i,
  output logic                    a_lo_o,
  output logic                    a_lo_oe,
  input  logic                    a_hi_i,
  output logic                    a_hi_o,
  output logic                    a_hi_oe,
  input  logic                    b_lo_i,
  output logic                    b_lo_o,
  output logic                    b_lo_oe,
  input  logic                    b_hi_i,
  output logic                    b_hi_o,
  output logic                    b_hi_oe,
  output logic [4*HALF_W-1:0]     seg_lvl
);

  localparam int CHANNELS = 2 * HALF_W;
  localparam int NSYNC    = 6;

  logic [NSYNC-1:0] raw_in, sync_out;
  logic             sclk_s, strobe_s;
  logic             a_lo_s, a_hi_s, b_lo_s, b_hi_s;
  logic             sclk_d;
  logic             shift_fall;
  logic [HALF_W-1:0]   a_cells, b_cells;
  logic [CHANNELS-1:0] all_cells;
  logic [CHANNELS-1:0] latch_q;

  assign raw_in = {shift_clk, latch_strb, a_lo_i, a_hi_i, b_lo_i, b_hi_i};

  lcdseg_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_in),
    .dout(sync_out)
  );

  assign {sclk_s, strobe_s, a_lo_s, a_hi_s, b_lo_s, b_hi_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign shift_fall = sclk_d & ~sclk_s;

  lcdseg_half #(.WIDTH(HALF_W)) u_half_a (
    .clk       (clk),
    .rst       (rst),
    .shift_evt (shift_fall),
    .toward_lo (dir_a),
    .ser_lo_in (a_lo_s),
    .ser_hi_in (a_hi_s),
    .ser_lo_out(a_lo_o),
    .ser_lo_oe (a_lo_oe),
    .ser_hi_out(a_hi_o),
    .ser_hi_oe (a_hi_oe),
    .cells     (a_cells)
  );

  lcdseg_half #(.WIDTH(HALF_W)) u_half_b (
    .clk       (clk),
    .rst       (rst),
    .shift_evt (shift_fall),
    .toward_lo (dir_b),
    .ser_lo_in (b_lo_s),
    .ser_hi_in (b_hi_s),
    .ser_lo_out(b_lo_o),
    .ser_lo_oe (b_lo_oe),
    .ser_hi_out(b_hi_o),
    .ser_hi_oe (b_hi_oe),
    .cells     (b_cells)
  );

  assign all_cells = {b_cells, a_cells};

  always_ff @(posedge clk) begin
    if (rst)           latch_q <= '0;
    else if (strobe_s) latch_q <= all_cells;
  end

  lcdseg_level #(.CHANNELS(CHANNELS)) u_level (
    .dots(latch_q),
    .alt (frame_alt),
    .lvl (seg_lvl)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> latch_q == '0); // R1
  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
    shift_fall |=> !shift_fall); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe_s |=> $stable(latch_q)); // R8
  AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    strobe_s |=> latch_q == $past(all_cells)); // R8

endmodule

// File: tb/test_lcd_seg_driver.sv
`timescale 1ns/1ps
module test_lcd_seg_driver;

  localparam int HW = 40;
  localparam int CH = 2 * HW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, shift_clk, latch_strb, frame_alt, dir_a, dir_b;
  logic a_lo_i, a_hi_i, b_lo_drv, b_hi_i, b_lo_i;
  logic a_lo_o, a_lo_oe, a_hi_o, a_hi_oe, b_lo_o, b_lo_oe, b_hi_o, b_hi_oe;
  logic [2*CH-1:0] seg_lvl;
  logic chain;

  assign b_lo_i = chain ? a_hi_o : b_lo_drv;

  lcd_seg_driver i_lcd_seg_driver (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .latch_strb(latch_strb),
    .frame_alt(frame_alt), .dir_a(dir_a), .dir_b(dir_b),
    .a_lo_i(a_lo_i), .a_lo_o(a_lo_o), .a_lo_oe(a_lo_oe),
    .a_hi_i(a_hi_i), .a_hi_o(a_hi_o), .a_hi_oe(a_hi_oe),
    .b_lo_i(b_lo_i), .b_lo_o(b_lo_o), .b_lo_oe(b_lo_oe),
    .b_hi_i(b_hi_i), .b_hi_o(b_hi_o), .b_hi_oe(b_hi_oe),
    .seg_lvl(seg_lvl)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  logic [HW-1:0] ma, mb;
  logic [CH-1:0] ml;
  logic [CH-1:0] first_bits;

  function automatic logic [1:0] exp_code(input logic dot, input logic alt);
    if (alt) return dot ? 2'b11 : 2'b10;
    else     return dot ? 2'b00 : 2'b01;
  endfunction

  function automatic logic [2*CH-1:0] exp_bus(input logic [CH-1:0] dots, input logic alt);
    logic [2*CH-1:0] v;
    for (int c = 0; c < CH; c++) v[2*c +: 2] = exp_code(dots[c], alt);
    return v;
  endfunction

  task automatic chk(input string req, input logic [2*CH-1:0] act, input logic [2*CH-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_seg(input string req);
    chk(req, seg_lvl, exp_bus(ml, frame_alt));
  endtask

  // R9: enables and serial outputs per half, packed {lo_oe,hi_oe,lo_o,hi_o}
  task automatic chk_serial(input string req);
    logic [7:0] act, exp;
    act = {a_lo_oe, a_hi_oe, a_lo_o, a_hi_o, b_lo_oe, b_hi_oe, b_lo_o, b_hi_o};
    exp = {dir_a, ~dir_a, dir_a ? ma[0] : 1'b0, dir_a ? 1'b0 : ma[HW-1],
           dir_b, ~dir_b, dir_b ? mb[0] : 1'b0, dir_b ? 1'b0 : mb[HW-1]};
    chk(req, {{(2*CH-8){1'b0}}, act}, {{(2*CH-8){1'b0}}, exp});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic alo, input logic ahi, input logic blo, input logic bhi);
    logic old_a_top, bin;
    @(negedge clk);
    a_lo_i = alo; a_hi_i = ahi; b_lo_drv = blo; b_hi_i = bhi;
    wait_cyc(1);
    shift_clk = 1'b1;
    wait_cyc(4);
    shift_clk = 1'b0;
    wait_cyc(6);
    old_a_top = ma[HW-1];
    if (!dir_a) ma = {ma[HW-2:0], alo};
    else        ma = {ahi, ma[HW-1:1]};
    bin = chain ? old_a_top : blo;
    if (!dir_b) mb = {mb[HW-2:0], bin};
    else        mb = {bhi, mb[HW-1:1]};
    if (latch_strb) ml = {mb, ma};
  endtask

  task automatic strobe();
    @(negedge clk);
    latch_strb = 1'b1;
    wait_cyc(6);
    latch_strb = 1'b0;
    ml = {mb, ma};
    wait_cyc(6);
  endtask

  task automatic fill_random(input int n);
    for (int i = 0; i < n; i++)
      shift_bits($urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; shift_clk = 1'b0; latch_strb = 1'b0; frame_alt = 1'b0;
    dir_a = 1'b0; dir_b = 1'b0; chain = 1'b0;
    a_lo_i = 1'b0; a_hi_i = 1'b0; b_lo_drv = 1'b0; b_hi_i = 1'b0;
    ma = '0; mb = '0; ml = '0;
    wait_cyc(5);
    // R1: reset state, both alternation phases
    chk_seg("R1 reset alt0");
    frame_alt = 1'b1;
    wait_cyc(1);
    chk_seg("R1 reset alt1");
    chk_serial("R1 serial after reset");
    @(negedge clk) rst = 1'b0;
    wait_cyc(2);
    chk_seg("R1 first cycles after reset");

    // R3..R6, R9: every direction combination, full random load
    for (int combo = 0; combo < 4; combo++) begin
      @(negedge clk);
      dir_a = combo[0]; dir_b = combo[1];
      frame_alt = $urandom_range(0, 1);
      fill_random(HW);
      strobe();
      case (combo)
        0: chk_seg("R3 R5 a up b up");
        1: chk_seg("R4 R5 a down b up");
        2: chk_seg("R3 R6 a up b down");
        default: chk_seg("R4 R6 a down b down");
      endcase
      chk_serial("R9 R3 R4 R5 R6 serial pins");
    end

    // R2: alternation flips the codes without re-latching
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) frame_alt = ~frame_alt;
      wait_cyc(1);
      chk_seg("R2 alternation change");
    end

    // R2: directed dot patterns in both phases
    dir_a = 1'b0; dir_b = 1'b0;
    for (int i = 0; i < HW; i++) shift_bits(i[0], 1'b0, ~i[0], 1'b0);
    strobe();
    frame_alt = 1'b0; wait_cyc(1); chk_seg("R2 alternating dots alt0");
    frame_alt = 1'b1; wait_cyc(1); chk_seg("R2 alternating dots alt1");

    // R8: strobe low holds the pattern through further shifting
    fill_random(10);
    chk_seg("R8 hold while strobe low");

    // R8: strobe high follows shifting
    @(negedge clk) latch_strb = 1'b1;
    wait_cyc(6);
    ml = {mb, ma};
    fill_random(5);
    chk_seg("R8 follow while strobe high");

    // R7: rising edge and steady high level do not shift
    @(negedge clk);
    a_lo_i = ~ma[HW-1]; b_lo_drv = ~mb[HW-1];
    shift_clk = 1'b1;
    wait_cyc(12);
    chk_seg("R7 no shift on rising edge");
    chk_serial("R7 serial steady on rising edge");
    shift_clk = 1'b0;
    wait_cyc(6);
    ma = {ma[HW-2:0], a_lo_i};
    mb = {mb[HW-2:0], b_lo_drv};
    ml = {mb, ma};
    chk_seg("R7 shift on falling edge");
    @(negedge clk) latch_strb = 1'b0;
    wait_cyc(6);

    // R10: cascade the halves into one 80-bit chain
    chain = 1'b1; dir_a = 1'b0; dir_b = 1'b0;
    for (int i = 0; i < CH; i++) begin
      first_bits[i] = $urandom_range(0, 1);
      shift_bits(first_bits[i], 1'b0, 1'b0, 1'b0);
    end
    strobe();
    chk_seg("R10 chained 80-bit load");
    begin
      logic [CH-1:0] rev;
      for (int i = 0; i < CH; i++) rev[CH-1-i] = first_bits[i];
      chk("R10 first bit at channel 80", {{(2*CH-1){1'b0}}, seg_lvl[2*CH-1:2*CH-2] == exp_code(rev[CH-1], frame_alt)},
          {{(2*CH-1){1'b0}}, 1'b1});
      chk("R10 last bit at channel 1", {{(2*CH-1){1'b0}}, seg_lvl[1:0] == exp_code(rev[0], frame_alt)},
          {{(2*CH-1){1'b0}}, 1'b1});
    end
    chain = 1'b0;

    // R1: reset mid-run clears the pattern
    @(negedge clk) rst = 1'b1;
    wait_cyc(3);
    ma = '0; mb = '0; ml = '0;
    chk_seg("R1 reset after load");
    chk_serial("R1 serial after second reset");
    @(negedge clk) rst = 1'b0;
    wait_cyc(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule